// File: doc/BRIEF.md
# Companion-Chip System Control Register File

This block is the byte-wide control register file of a companion I/O device. Up to eight internal sub-units each drive a level interrupt line. The block mirrors each line into a status byte and raises one host interrupt whenever a status bit is set and its mask bit is also set. It also holds a bank of general-purpose outputs with separate data and output-enable registers. It presents the driven level of each of the low sixteen lines (data AND enable) on a notification output, which changes only when a data or enable byte is written.

The host uses a plain 8-bit register bus. A write takes effect on the rising clock edge while the write enable is high. A read is combinational from the address. Wider registers are reached one byte at a time, with the least significant byte at the lowest offset. A group of clock, PLL, buffer and mode registers is plain storage with no side effects. Any offset that is not mapped reads as zero and ignores writes.

Top module: `ioc_sysctl`

## Requirements
- R1: After reset every readable register except the revision byte reads 0x00, `hostIrq` is low and every `gpioNotify` bit is low.
- R2: The status register is at offset 0x50, and bit i stands for sub-unit line i (0 flash controller, 1 card slot, 2 USB host, 3 serial, 4 display). When line i changes level, bit i takes the new level at the clock edge that samples the change. It is set when the line rose and cleared when it fell.
- R3: `hostIrq` is high exactly when some bit is set in both the status register and the mask register at offset 0x52. It follows a change in either register without further delay.
- R4: A host write to offset 0x50 replaces the whole status byte. If a sub-unit line changes in the same cycle, that line's bit takes the line level instead. A bit whose line does not change keeps the written value.
- R5: Offset 0x08 reads 0x03 (revision) and offset 0x09 reads 0x00. Writes to either have no effect.
- R6: Output data bytes are at 0x78, 0x79 and 0x7A, and output-enable bytes are at 0x7C, 0x7D and 0x7E. Byte k holds bits 8k+7..8k. Every byte reads back the value last written to it, and a write changes only the addressed byte.
- R7: `gpioNotify[i]` equals data bit i AND enable bit i for i in 0..15. It is updated at the edge of any data or enable byte write and holds otherwise. Bits 16..23 of both registers do not affect it.
- R8: The routing byte at 0x54 and the plain storage bytes read back what was last written to them. The storage bytes are 0x60-0x61, 0x98-0x9F, 0xE0, 0xE4-0xE5, 0xFC and 0xFF. A byte write leaves the neighbouring bytes of the same wide register unchanged.
- R9: Offsets that are not listed above read 0x00. A write to them changes no register, no notification output and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register byte offset |
| busWrEn | input | 1 | Write strobe, sampled on the rising edge |
| busWrData | input | 8 | Write data byte |
| busRdData | output | 8 | Combinational read data for `busAddr` |
| unitIrq | input | NUM_UNITS (8) | Level interrupt lines from the sub-units |
| hostIrq | output | 1 | Combined masked interrupt to the host |
| gpioNotify | output | NUM_GPIO (16) | Driven level (data AND enable) per output line |

## Verification
Directed cases raise and lower single sub-unit lines with the mask open and closed. This separates the status mirror from the mask gating. One case writes the status byte in the same cycle as a line edge, which shows that the line wins only for its own bit. The output lines are exercised by writing data before enable and enable before data in each lane, plus the unused third lane. This catches a notification taken from data alone, from enable alone, or from stale values. A seeded random phase then mixes writes to mapped and unmapped offsets with toggling sub-unit lines. Every cycle it compares the interrupt, the notification outputs and a random read against a bench model, which exposes decode aliasing and writes leaking into neighbouring bytes.

// File: rtl/ioc_sysctl_pkg.sv
package ioc_sysctl_pkg;

  localparam int UNIT_MAX   = 8;
  localparam int GPIO_BYTES = 3;
  localparam int GB_W       = $clog2(GPIO_BYTES);

  localparam logic [7:0] REV_VALUE = 8'h03;

  localparam logic [7:0] ADDR_REV_LO   = 8'h08;
  localparam logic [7:0] ADDR_REV_HI   = 8'h09;
  localparam logic [7:0] ADDR_STATUS   = 8'h50;
  localparam logic [7:0] ADDR_MASK     = 8'h52;
  localparam logic [7:0] ADDR_ROUTE    = 8'h54;
  localparam logic [7:0] ADDR_OUT_DATA = 8'h78;
  localparam logic [7:0] ADDR_OUT_EN   = 8'h7C;
  localparam logic [7:0] ADDR_OUT_DATA_END = ADDR_OUT_DATA + 8'(GPIO_BYTES);
  localparam logic [7:0] ADDR_OUT_EN_END   = ADDR_OUT_EN + 8'(GPIO_BYTES);

  // plain storage bytes: enable word, clock/PLL words, function, mode, config, debug
  localparam int NUM_STORE = 15;
  localparam int ST_W      = $clog2(NUM_STORE);
  localparam logic [7:0] STORE_ADDR [NUM_STORE] = '{
    8'h60, 8'h61,
    8'h98, 8'h99, 8'h9A, 8'h9B, 8'h9C, 8'h9D, 8'h9E, 8'h9F,
    8'hE0, 8'hE4, 8'hE5,
    8'hFC, 8'hFF
  };

  typedef struct packed {
    logic                  status;
    logic                  mask;
    logic                  route;
    logic [GPIO_BYTES-1:0] outData;
    logic [GPIO_BYTES-1:0] outEn;
    logic [NUM_STORE-1:0]  store;
  } wr_strobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_REV,
    RD_STATUS,
    RD_MASK,
    RD_ROUTE,
    RD_DATA,
    RD_EN,
    RD_STORE
  } rd_sel_t;

  typedef struct packed {
    rd_sel_t         sel;
    logic [ST_W-1:0] idx;
  } rd_req_t;

endpackage

// File: rtl/ioc_sysctl_ctrl.sv
module ioc_sysctl_ctrl
  import ioc_sysctl_pkg::*;
(
  input  logic [7:0]  busAddr,
  input  logic        busWrEn,
  output wr_strobe_t  wrStb,
  output rd_req_t     rdReq
);

  always_comb begin
    wrStb     = '0;
    rdReq.sel = RD_NONE;
    rdReq.idx = '0;

    if (busAddr == ADDR_REV_LO) begin
      rdReq.sel = RD_REV;
    end else if (busAddr == ADDR_REV_HI) begin
      rdReq.sel = RD_NONE;           // upper revision byte reads zero
    end else if (busAddr == ADDR_STATUS) begin
      rdReq.sel    = RD_STATUS;
      wrStb.status = busWrEn;
    end else if (busAddr == ADDR_MASK) begin
      rdReq.sel  = RD_MASK;
      wrStb.mask = busWrEn;
    end else if (busAddr == ADDR_ROUTE) begin
      rdReq.sel   = RD_ROUTE;
      wrStb.route = busWrEn;
    end else if (busAddr >= ADDR_OUT_DATA && busAddr < ADDR_OUT_DATA_END) begin
      rdReq.sel = RD_DATA;
      rdReq.idx = ST_W'(busAddr - ADDR_OUT_DATA);
      for (int k = 0; k < GPIO_BYTES; k++) begin
        if (busAddr == ADDR_OUT_DATA + 8'(k)) wrStb.outData[k] = busWrEn;
      end
    end else if (busAddr >= ADDR_OUT_EN && busAddr < ADDR_OUT_EN_END) begin
      rdReq.sel = RD_EN;
      rdReq.idx = ST_W'(busAddr - ADDR_OUT_EN);
      for (int k = 0; k < GPIO_BYTES; k++) begin
        if (busAddr == ADDR_OUT_EN + 8'(k)) wrStb.outEn[k] = busWrEn;
      end
    end else begin
      for (int i = 0; i < NUM_STORE; i++) begin
        if (busAddr == STORE_ADDR[i]) begin
          rdReq.sel      = RD_STORE;
          rdReq.idx      = ST_W'(i);
          wrStb.store[i] = busWrEn;
        end
      end
    end
  end

endmodule

// File: rtl/ioc_sysctl_dp.sv
module ioc_sysctl_dp
  import ioc_sysctl_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int NUM_GPIO  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wr_strobe_t           wrStb,
  input  rd_req_t              rdReq,
  input  logic [7:0]           wrData,
  input  logic [NUM_UNITS-1:0] unitIrq,
  output logic [7:0]           rdData,
  output logic                 hostIrq,
  output logic [NUM_GPIO-1:0]  gpioNotify,
  output logic [NUM_UNITS-1:0] statusVal,
  output logic [NUM_UNITS-1:0] maskVal
);

  localparam int OUT_W = GPIO_BYTES * 8;

  // ---------------- interrupt status / mask ----------------
  logic [NUM_UNITS-1:0] statusQ, statusNext;
  logic [NUM_UNITS-1:0] maskQ;
  logic [NUM_UNITS-1:0] unitPrevQ;
  logic [NUM_UNITS-1:0] unitChg;
  logic [7:0]           routeQ;

  assign unitChg = unitIrq ^ unitPrevQ;

  always_comb begin
    statusNext = wrStb.status ? wrData[NUM_UNITS-1:0] : statusQ;
    statusNext = (statusNext & ~unitChg) | (unitIrq & unitChg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ   <= '0;
      maskQ     <= '0;
      routeQ    <= '0;
      unitPrevQ <= '0;
    end else begin
      statusQ   <= statusNext;
      unitPrevQ <= unitIrq;
      if (wrStb.mask)  maskQ  <= wrData[NUM_UNITS-1:0];
      if (wrStb.route) routeQ <= wrData;
    end
  end

  assign hostIrq   = |(statusQ & maskQ);
  assign statusVal = statusQ;
  assign maskVal   = maskQ;

  // ---------------- general-purpose outputs ----------------
  logic [OUT_W-1:0] outDataQ, outEnQ;
  logic [OUT_W-1:0] dataNext, enNext;
  logic [7:0]       dataByte [GPIO_BYTES];
  logic [7:0]       enByte   [GPIO_BYTES];
  logic [NUM_GPIO-1:0] notifyQ;
  logic             outWr;

  for (genvar k = 0; k < GPIO_BYTES; k++) begin : g_lane
    assign dataNext[8*k +: 8] = wrStb.outData[k] ? wrData : outDataQ[8*k +: 8];
    assign enNext[8*k +: 8]   = wrStb.outEn[k]   ? wrData : outEnQ[8*k +: 8];
    assign dataByte[k]        = outDataQ[8*k +: 8];
    assign enByte[k]          = outEnQ[8*k +: 8];
  end

  assign outWr = (|wrStb.outData) | (|wrStb.outEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outDataQ <= '0;
      outEnQ   <= '0;
      notifyQ  <= '0;
    end else begin
      outDataQ <= dataNext;
      outEnQ   <= enNext;
      if (outWr) notifyQ <= dataNext[NUM_GPIO-1:0] & enNext[NUM_GPIO-1:0];
    end
  end

  assign gpioNotify = notifyQ;

  // ---------------- plain storage ----------------
  logic [7:0] storeQ [NUM_STORE];

  for (genvar i = 0; i < NUM_STORE; i++) begin : g_store
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               storeQ[i] <= '0;
      else if (wrStb.store[i]) storeQ[i] <= wrData;
    end
  end

  // ---------------- read mux ----------------
  always_comb begin
    rdData = '0;
    case (rdReq.sel)
      RD_REV:    rdData = REV_VALUE;
      RD_STATUS: rdData = 8'(statusQ);
      RD_MASK:   rdData = 8'(maskQ);
      RD_ROUTE:  rdData = routeQ;
      RD_DATA:   rdData = dataByte[rdReq.idx[GB_W-1:0]];
      RD_EN:     rdData = enByte[rdReq.idx[GB_W-1:0]];
      RD_STORE:  rdData = storeQ[rdReq.idx];
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/ioc_sysctl.sv
module ioc_sysctl
  import ioc_sysctl_pkg::*;
#(
  parameter int NUM_UNITS = UNIT_MAX,
  parameter int NUM_GPIO  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:0]           busAddr,
  input  logic                 busWrEn,
  input  logic [7:0]           busWrData,
  output logic [7:0]           busRdData,
  input  logic [NUM_UNITS-1:0] unitIrq,
  output logic                 hostIrq,
  output logic [NUM_GPIO-1:0]  gpioNotify
);

  wr_strobe_t           wrStb;
  rd_req_t              rdReq;
  logic [NUM_UNITS-1:0] statusVal;
  logic [NUM_UNITS-1:0] maskVal;

  ioc_sysctl_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .wrStb   (wrStb),
    .rdReq   (rdReq)
  );

  ioc_sysctl_dp #(
    .NUM_UNITS (NUM_UNITS),
    .NUM_GPIO  (NUM_GPIO)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrStb      (wrStb),
    .rdReq      (rdReq),
    .wrData     (busWrData),
    .unitIrq    (unitIrq),
    .rdData     (busRdData),
    .hostIrq    (hostIrq),
    .gpioNotify (gpioNotify),
    .statusVal  (statusVal),
    .maskVal    (maskVal)
  );

endmodule

// File: rtl/ioc_sysctl_chk.sv
module ioc_sysctl_chk
  import ioc_sysctl_pkg::*;
#(
  parameter int NUM_UNITS = 8,
  parameter int NUM_GPIO  = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [7:0]           busAddr,
  input logic                 busWrEn,
  input logic [NUM_UNITS-1:0] unitIrq,
  input logic                 hostIrq,
  input logic [NUM_GPIO-1:0]  gpioNotify,
  input logic [NUM_UNITS-1:0] statusVal,
  input logic [NUM_UNITS-1:0] maskVal
);

  logic armed;
  logic outWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assign outWrite = busWrEn &&
    ((busAddr >= ADDR_OUT_DATA && busAddr < ADDR_OUT_DATA_END) ||
     (busAddr >= ADDR_OUT_EN   && busAddr < ADDR_OUT_EN_END));

  // R2: a changed line lands in its status bit one edge later
  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_line
    a_r2_status_follows_line: assert property (
      @(posedge clk) disable iff (!rstN)
      (armed && unitIrq[i] != $past(unitIrq[i])) |=> (statusVal[i] == $past(unitIrq[i])));
  end

  // R3: with no write and no line change the host interrupt holds
  a_r3_irq_quiet: assert property (
    @(posedge clk) disable iff (!rstN)
    (armed && !busWrEn && unitIrq == $past(unitIrq)) |=> $stable(hostIrq));

  // R3: a fully closed mask never lets the interrupt out
  a_r3_mask_closed: assert property (
    @(posedge clk) disable iff (!rstN)
    (maskVal == '0) |-> !hostIrq);

  // R7: notification outputs move only on an output data/enable write
  a_r7_notify_hold: assert property (
    @(posedge clk) disable iff (!rstN)
    !outWrite |=> $stable(gpioNotify));

endmodule

bind ioc_sysctl ioc_sysctl_chk #(
  .NUM_UNITS (NUM_UNITS),
  .NUM_GPIO  (NUM_GPIO)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWrEn    (busWrEn),
  .unitIrq    (unitIrq),
  .hostIrq    (hostIrq),
  .gpioNotify (gpioNotify),
  .statusVal  (statusVal),
  .maskVal    (maskVal)
);

// File: tb/ioc_sysctl_bench.sv
`timescale 1ns/1ps
module ioc_sysctl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [7:0]  unitIrq = '0;
  logic        hostIrq;
  logic [15:0] gpioNotify;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  ioc_sysctl u_ioc_sysctl (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .unitIrq    (unitIrq),
    .hostIrq    (hostIrq),
    .gpioNotify (gpioNotify)
  );

  // ---------------- reference model ----------------
  logic [7:0]  mStatus = '0, mMask = '0, mRoute = '0, mPrevU = '0;
  logic [23:0] mData = '0, mEn = '0;
  logic [15:0] mNotify = '0;
  logic [7:0]  mStore [256];

  function automatic bit isStore(logic [7:0] a);
    case (a)
      8'h60, 8'h61, 8'h98, 8'h99, 8'h9A, 8'h9B, 8'h9C, 8'h9D, 8'h9E, 8'h9F,
      8'hE0, 8'hE4, 8'hE5, 8'hFC, 8'hFF: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit isOut(logic [7:0] a);
    return (a >= 8'h78 && a <= 8'h7A) || (a >= 8'h7C && a <= 8'h7E);
  endfunction

  function automatic logic [7:0] mRead(logic [7:0] a);
    if (a == 8'h08) return 8'h03;
    if (a == 8'h50) return mStatus;
    if (a == 8'h52) return mMask;
    if (a == 8'h54) return mRoute;
    if (a >= 8'h78 && a <= 8'h7A) return mData[8*(a-8'h78) +: 8];
    if (a >= 8'h7C && a <= 8'h7E) return mEn[8*(a-8'h7C) +: 8];
    if (isStore(a)) return mStore[a];
    return 8'h00;
  endfunction

  function automatic string tagOf(logic [7:0] a);
    if (a == 8'h08 || a == 8'h09) return "R5";
    if (a == 8'h50) return "R2";
    if (a == 8'h52) return "R3";
    if (a == 8'h54 || isStore(a)) return "R8";
    if (isOut(a)) return "R6";
    return "R9";
  endfunction

  task automatic mWrite(logic [7:0] a, logic [7:0] d);
    if (a == 8'h50) mStatus = d;
    else if (a == 8'h52) mMask = d;
    else if (a == 8'h54) mRoute = d;
    else if (a >= 8'h78 && a <= 8'h7A) mData[8*(a-8'h78) +: 8] = d;
    else if (a >= 8'h7C && a <= 8'h7E) mEn[8*(a-8'h7C) +: 8] = d;
    else if (isStore(a)) mStore[a] = d;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: optional write plus unit line levels; checks irq and notify after the edge
  task automatic step(bit we, logic [7:0] a, logic [7:0] d, logic [7:0] u);
    logic [7:0] chg;
    @(negedge clk);
    busWrEn = we; busAddr = a; busWrData = d; unitIrq = u;
    @(posedge clk);
    chg = u ^ mPrevU;
    if (we) mWrite(a, d);
    mStatus = (mStatus & ~chg) | (u & chg);
    mPrevU  = u;
    if (we && isOut(a)) mNotify = mData[15:0] & mEn[15:0];
    #1;
    check("R3 hostIrq", 32'(hostIrq), 32'(|(mStatus & mMask)));
    check("R7 gpioNotify", 32'(gpioNotify), 32'(mNotify));
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdChk(string tag, logic [7:0] a, logic [7:0] exp);
    @(negedge clk);
    busWrEn = 1'b0; busAddr = a;
    #1;
    check(tag, 32'(busRdData), 32'(exp));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 4);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] u;
    logic [7:0] interesting [12];
    for (int i = 0; i < 256; i++) mStore[i] = 8'h00;
    void'($urandom(32'h1A2B3C4D));
    interesting = '{8'h50, 8'h52, 8'h54, 8'h78, 8'h79, 8'h7A,
                    8'h7C, 8'h7D, 8'h7E, 8'h9C, 8'h7B, 8'h51};

    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    #1;
    check("R1 hostIrq", 32'(hostIrq), 0);
    check("R1 gpioNotify", 32'(gpioNotify), 0);
    rdChk("R1 status", 8'h50, 8'h00);
    rdChk("R1 mask",   8'h52, 8'h00);
    rdChk("R1 data0",  8'h78, 8'h00);
    rdChk("R1 en2",    8'h7E, 8'h00);
    rdChk("R1 pll",    8'h9F, 8'h00);
    rdChk("R1 debug",  8'hFF, 8'h00);

    // R5: revision
    rdChk("R5 rev lo", 8'h08, 8'h03);
    rdChk("R5 rev hi", 8'h09, 8'h00);
    step(1, 8'h08, 8'hAA, 8'h00);
    rdChk("R5 rev lo after write", 8'h08, 8'h03);

    // R2/R3: mirror and mask
    step(0, 8'h00, 8'h00, 8'h04);
    rdChk("R2 line2 high", 8'h50, 8'h04);
    check("R3 masked off", 32'(hostIrq), 0);
    step(1, 8'h52, 8'h04, 8'h04);
    check("R3 mask open", 32'(hostIrq), 1);
    step(0, 8'h00, 8'h00, 8'h00);
    rdChk("R2 line2 low", 8'h50, 8'h00);
    check("R3 line low", 32'(hostIrq), 0);

    // R4: host write vs line change
    step(0, 8'h00, 8'h00, 8'h01);
    step(1, 8'h50, 8'hF0, 8'h01);
    rdChk("R4 write replaces", 8'h50, 8'hF0);
    step(1, 8'h50, 8'h00, 8'h03);
    rdChk("R4 line wins own bit", 8'h50, 8'h02);

    // R6/R7: output lanes
    step(1, 8'h78, 8'hFF, 8'h03);
    check("R7 data only", 32'(gpioNotify), 32'h0000);
    step(1, 8'h7C, 8'h0F, 8'h03);
    check("R7 lane0", 32'(gpioNotify), 32'h000F);
    step(1, 8'h7D, 8'hFF, 8'h03);
    step(1, 8'h79, 8'hA5, 8'h03);
    check("R7 lane1", 32'(gpioNotify), 32'hA50F);
    step(1, 8'h7A, 8'hFF, 8'h03);
    step(1, 8'h7E, 8'hFF, 8'h03);
    check("R7 lane2 no effect", 32'(gpioNotify), 32'hA50F);
    rdChk("R6 data1", 8'h79, 8'hA5);
    rdChk("R6 en0",   8'h7C, 8'h0F);
    rdChk("R6 data2", 8'h7A, 8'hFF);

    // R8: storage bytes
    step(1, 8'h9C, 8'h11, 8'h03);
    step(1, 8'h9D, 8'h22, 8'h03);
    step(1, 8'h9E, 8'h33, 8'h03);
    step(1, 8'h9D, 8'h5A, 8'h03);
    rdChk("R8 pll b0", 8'h9C, 8'h11);
    rdChk("R8 pll b1", 8'h9D, 8'h5A);
    rdChk("R8 pll b2", 8'h9E, 8'h33);
    step(1, 8'h54, 8'hC3, 8'h03);
    rdChk("R8 route", 8'h54, 8'hC3);

    // R9: unmapped
    step(1, 8'h51, 8'hFF, 8'h03);
    step(1, 8'h7B, 8'hFF, 8'h03);
    step(1, 8'h00, 8'hFF, 8'h03);
    step(1, 8'hFE, 8'hFF, 8'h03);
    rdChk("R9 read 51", 8'h51, 8'h00);
    rdChk("R9 read 7B", 8'h7B, 8'h00);
    rdChk("R9 read FE", 8'hFE, 8'h00);
    for (int a = 0; a < 256; a++) begin
      rdChk(tagOf(8'(a)), 8'(a), mRead(8'(a)));
    end

    // random phase
    u = 8'h03;
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      if ($urandom % 3 == 0) u = u ^ (8'h01 << ($urandom % 8));
      if ($urandom % 2 == 0) a = interesting[$urandom % 12];
      else                   a = 8'($urandom);
      step(($urandom % 2) == 1, a, 8'($urandom), u);
      a = 8'($urandom);
      rdChk(tagOf(a), a, mRead(a));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule